// File: doc/BRIEF.md
# DSP Load/Store Address Generator

This block carries out the register-indirect memory moves of a small 16-bit DSP. It holds four 16-bit pointer registers and their four index partners. Each operation names one pointer. The block presents that pointer to data memory and then adjusts the pointer by one of four rules: leave it alone, step it down by one, step it up by one, or add its index partner. Loads place the memory word into any register of a 32-entry register space. Stores send any register of that space to memory. Registers 0 to 7 are the pointers and index registers kept in this block. Registers 8 to 31 belong to an outside register file, which the block reads through `src_raddr`/`src_data` and writes through the `rf_*` port.

Two compact extended forms use the same mechanism. They only allow post-increment or index-add. An extended load targets one of four fixed registers from 0x18 upward. An extended store sources one of four fixed registers from 0x1C upward. Extended forms do not advance the program counter. Data memory is a synchronous RAM, so a loaded word is written back one cycle after its address is shown. During that cycle the word is forwarded to any reader, so back-to-back operations behave in program order.

Top module: `dsp_ldst_agu`

## Requirements
- R1: After reset all eight internal registers read 0, and with no operation presented `mem_re`, `mem_we`, `rf_we` and `pc_step` are 0.
- R2: Pointer n (n = 0..3) is register n and its index partner is register n+4; normal loads and stores with `reg_sel` 0..7 reach these internal registers.
- R3: Codes 0, 1, 2 and 3 are loads with pointer update keep, minus one, plus one and plus index. `mem_re`=1 and `mem_addr` is the pointer value before its update.
- R4: Codes 4, 5, 6 and 7 are stores with the same four updates in the same order. `mem_we`=1, `mem_addr` is the old pointer, `mem_wdata` is register `reg_sel`, and `src_raddr` names that register.
- R5: One cycle after a load, `rf_we`=1, `rf_waddr` is the load's destination and `rf_wdata` equals `mem_rdata`. A destination of 0..7 also updates the internal register.
- R6: Code 8 (post-increment) and code 9 (index-add) are extended loads into register 0x18 + `reg_sel[1:0]`.
- R7: Code 10 (post-increment) and code 11 (index-add) are extended stores from register 0x1C + `reg_sel[1:0]`.
- R8: `pc_step` is 1 for a valid code 0..7 and 0 for the extended codes and when idle.
- R9: When a load's destination is its own pointer, the loaded word replaces the post-updated pointer.
- R10: An operation in the cycle right after a load sees the loaded word as pointer, index or store source. A pointer update in that cycle overrides the write-back of the same register.
- R11: With `op_valid`=0 or codes 12..15 there is no memory access, no `pc_step` and no register change.
- R12: Increment, decrement and index-add wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Decoded operation code (see R3, R4, R6, R7) |
| ptr_sel | input | 2 | Pointer register number |
| reg_sel | input | 5 | Data register number, or bank field in bits 1:0 for extended forms |
| src_raddr | output | 5 | Register number a store reads |
| src_data | input | 16 | Outside register file read data for `src_raddr` |
| mem_addr | output | 16 | Data memory address |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 16 | Data memory write data |
| mem_rdata | input | 16 | Data memory read data, one cycle after `mem_re` |
| rf_we | output | 1 | Register write-back strobe |
| rf_waddr | output | 5 | Register write-back number |
| rf_wdata | output | 16 | Register write-back data |
| pc_step | output | 1 | Program counter advances by one |

## Verification
The bench targets back-to-back hazards. These are a load into a pointer, index or store source followed at once by an operation that uses it. A design without forwarding would then use the stale value, and a design with the wrong write priority would keep the loaded word where the newer pointer update should stand. It also drives a load whose destination is its own pointer, which a design with the wrong priority would leave holding the incremented address. It steps a pointer below zero and past 0xFFFF, where a missing wrap shows up as a wrong next address. It sends extended forms, where a wrong bank base sends data to or from the wrong register, and codes 12..15, which a loose decoder would turn into memory accesses.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    // Pointer update rule applied after the access
    typedef enum logic [1:0] {
        PM_KEEP = 2'd0,
        PM_DEC  = 2'd1,
        PM_INC  = 2'd2,
        PM_IDX  = 2'd3
    } pm_mode_e;

    // Operation codes; the low two bits of codes 0..7 select the update rule
    typedef enum logic [3:0] {
        OP_LD      = 4'd0,
        OP_LD_DEC  = 4'd1,
        OP_LD_INC  = 4'd2,
        OP_LD_IDX  = 4'd3,
        OP_ST      = 4'd4,
        OP_ST_DEC  = 4'd5,
        OP_ST_INC  = 4'd6,
        OP_ST_IDX  = 4'd7,
        OP_XLD_INC = 4'd8,
        OP_XLD_IDX = 4'd9,
        OP_XST_INC = 4'd10,
        OP_XST_IDX = 4'd11
    } op_code_e;

    typedef struct packed {
        logic     is_load;
        logic     is_store;
        logic     step_pc;
        pm_mode_e mode;
    } ctl_t;

endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
#(
    parameter int RN_W     = 5,
    parameter int XBANK_W  = 2,
    parameter int XLD_BASE = 24,
    parameter int XST_BASE = 28
) (
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [RN_W-1:0] reg_sel,
    output ctl_t            ctl,
    output logic [RN_W-1:0] reg_num
);

    logic [RN_W-1:0] bank_off;
    assign bank_off = RN_W'(reg_sel[XBANK_W-1:0]);

    always_comb begin
        ctl     = '0;
        reg_num = reg_sel;
        if (op_valid) begin
            if (op_code < 4'd4) begin
                ctl.is_load = 1'b1;
                ctl.step_pc = 1'b1;
                ctl.mode    = pm_mode_e'(op_code[1:0]);
            end else if (op_code < 4'd8) begin
                ctl.is_store = 1'b1;
                ctl.step_pc  = 1'b1;
                ctl.mode     = pm_mode_e'(op_code[1:0]);
            end else if (op_code < 4'd10) begin
                ctl.is_load = 1'b1;
                ctl.mode    = op_code[0] ? PM_IDX : PM_INC;
                reg_num     = RN_W'(XLD_BASE) + bank_off;
            end else if (op_code < 4'd12) begin
                ctl.is_store = 1'b1;
                ctl.mode     = op_code[0] ? PM_IDX : PM_INC;
                reg_num      = RN_W'(XST_BASE) + bank_off;
            end
        end
    end

endmodule

// File: rtl/lsag_postmod.sv
module lsag_postmod
    import lsag_pkg::*;
#(
    parameter int DW = 16
) (
    input  pm_mode_e        mode,
    input  logic [DW-1:0]   ptr,
    input  logic [DW-1:0]   idx,
    output logic [DW-1:0]   nxt
);

    // All arithmetic is modulo 2^DW by truncation
    always_comb begin
        unique case (mode)
            PM_DEC:  nxt = ptr - DW'(1);
            PM_INC:  nxt = ptr + DW'(1);
            PM_IDX:  nxt = ptr + idx;
            default: nxt = ptr;
        endcase
    end

endmodule

// File: rtl/lsag_regfile.sv
module lsag_regfile #(
    parameter int DW   = 16,
    parameter int NPTR = 4,
    localparam int NREG = 2 * NPTR,
    localparam int PS_W = $clog2(NPTR),
    localparam int RF_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pm_we,
    input  logic [PS_W-1:0] pm_sel,
    input  logic [DW-1:0]   pm_val,
    input  logic            wb_we,
    input  logic [RF_W-1:0] wb_addr,
    input  logic [DW-1:0]   wb_val,
    output logic [DW-1:0]   regs_o [NREG]
);

    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    // A pointer update is younger than a pending write-back, so it is applied last
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (wb_we && wb_addr == RF_W'(i)) regs_d[i] = wb_val;
            if (pm_we && RF_W'(pm_sel) == RF_W'(i)) regs_d[i] = pm_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign regs_o = regs_q;

    // R10: same-edge collision resolves to the pointer update
    assert_pm_over_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_we && wb_we && wb_addr == RF_W'(pm_sel))
        |=> regs_q[$past(pm_sel)] == $past(pm_val));

    // R5: a lone write-back lands in its register
    assert_wb_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && !(pm_we && wb_addr == RF_W'(pm_sel)))
        |=> regs_q[$past(wb_addr)] == $past(wb_val));

endmodule

// File: rtl/dsp_ldst_agu.sv
module dsp_ldst_agu
    import lsag_pkg::*;
#(
    parameter int DW       = 16,
    parameter int NPTR     = 4,
    parameter int RN_W     = 5,
    parameter int XBANK_W  = 2,
    parameter int XLD_BASE = 24,
    parameter int XST_BASE = 28,
    localparam int NREG = 2 * NPTR,
    localparam int PS_W = $clog2(NPTR),
    localparam int RF_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [PS_W-1:0] ptr_sel,
    input  logic [RN_W-1:0] reg_sel,
    output logic [RN_W-1:0] src_raddr,
    input  logic [DW-1:0]   src_data,
    output logic [DW-1:0]   mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            rf_we,
    output logic [RN_W-1:0] rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            pc_step
);

    typedef struct packed {
        logic            wb_valid;
        logic [RN_W-1:0] wb_addr;
    } st_t;

    st_t st_d, st_q;

    ctl_t            ctl;
    logic [RN_W-1:0] reg_num;
    logic [DW-1:0]   regs_q    [NREG];
    logic [DW-1:0]   regs_view [NREG];
    logic [DW-1:0]   ptr_val, idx_val, src_val, nxt_ptr;
    logic            access;
    logic            wb_hit_src;

    lsag_decode #(
        .RN_W(RN_W), .XBANK_W(XBANK_W), .XLD_BASE(XLD_BASE), .XST_BASE(XST_BASE)
    ) u_dec (
        .op_valid(op_valid), .op_code(op_code), .reg_sel(reg_sel),
        .ctl(ctl), .reg_num(reg_num)
    );

    // Forward the word returning from memory to every reader of its register
    for (genvar g = 0; g < NREG; g++) begin : g_fwd
        assign regs_view[g] = (st_q.wb_valid && st_q.wb_addr == RN_W'(g))
                              ? mem_rdata : regs_q[g];
    end

    assign access     = ctl.is_load | ctl.is_store;
    assign ptr_val    = regs_view[RF_W'(ptr_sel)];
    assign idx_val    = regs_view[RF_W'(ptr_sel) + RF_W'(NPTR)];
    assign wb_hit_src = st_q.wb_valid && st_q.wb_addr == reg_num;

    always_comb begin
        if (reg_num < RN_W'(NREG)) src_val = regs_view[reg_num[RF_W-1:0]];
        else if (wb_hit_src)       src_val = mem_rdata;
        else                       src_val = src_data;
    end

    lsag_postmod #(.DW(DW)) u_pm (
        .mode(ctl.mode), .ptr(ptr_val), .idx(idx_val), .nxt(nxt_ptr)
    );

    lsag_regfile #(.DW(DW), .NPTR(NPTR)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .pm_we(access && ctl.mode != PM_KEEP), .pm_sel(ptr_sel), .pm_val(nxt_ptr),
        .wb_we(st_q.wb_valid && st_q.wb_addr < RN_W'(NREG)),
        .wb_addr(st_q.wb_addr[RF_W-1:0]), .wb_val(mem_rdata),
        .regs_o(regs_q)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wb_valid = ctl.is_load;
        st_d.wb_addr  = ctl.is_load ? reg_num : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = access ? ptr_val : '0;
    assign mem_re    = ctl.is_load;
    assign mem_we    = ctl.is_store;
    assign mem_wdata = ctl.is_store ? src_val : '0;
    assign src_raddr = ctl.is_store ? reg_num : '0;
    assign rf_we     = st_q.wb_valid;
    assign rf_waddr  = st_q.wb_addr;
    assign rf_wdata  = st_q.wb_valid ? mem_rdata : '0;
    assign pc_step   = ctl.step_pc;

    // R3: post-increment leaves old address + 1 in the pointer
    assert_post_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && ctl.mode == PM_INC)
        |=> regs_q[$past(ptr_sel)] == $past(mem_addr) + DW'(1));

    // R3: post-decrement leaves old address - 1 in the pointer
    assert_post_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && ctl.mode == PM_DEC)
        |=> regs_q[$past(ptr_sel)] == $past(mem_addr) - DW'(1));

    // R5: write-back follows a load by exactly one cycle
    assert_wb_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rf_we);
    assert_no_wb_without_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !rf_we);

    // R8: extended codes never advance the program counter
    assert_pc_normal_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |-> (op_valid && !op_code[3]));

    // R11: idle or undefined codes make no access
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code >= 4'd12) |-> (!mem_re && !mem_we && !pc_step));

endmodule

// File: tb/tb_dsp_ldst_agu.sv
module tb_dsp_ldst_agu;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  ptr_sel = '0;
    logic [4:0]  reg_sel = '0;
    logic [4:0]  src_raddr;
    logic [15:0] src_data;
    logic [15:0] mem_addr, mem_wdata, rf_wdata;
    logic [15:0] mem_rdata;
    logic        mem_re, mem_we, rf_we, pc_step;
    logic [4:0]  rf_waddr;

    always #(PERIOD/2) clk = ~clk;

    dsp_ldst_agu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .ptr_sel(ptr_sel), .reg_sel(reg_sel), .src_raddr(src_raddr),
        .src_data(src_data), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_step(pc_step)
    );

    // Environment: synchronous RAM (low 8 address bits) and outside register file
    logic [15:0] ram [256];
    logic [15:0] rdata_q = '0;
    logic [15:0] ext_rf [32];
    assign mem_rdata = rdata_q;
    assign src_data  = ext_rf[src_raddr];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) rdata_q <= ram[mem_addr[7:0]];
        if (rf_we)  ext_rf[rf_waddr] <= rf_wdata;
    end

    // Reference model in program order
    logic [15:0] m_reg [32];
    logic [15:0] m_mem [256];

    typedef struct {
        bit          re, we, pc, rfwe;
        logic [15:0] addr, wdata, rfd;
        logic [4:0]  rfa;
        string       tag, wtag;
    } exp_t;

    exp_t  q[$];
    bit          p_ld = 0;
    logic [4:0]  p_a = '0;
    logic [15:0] p_d = '0;
    string       p_tag = "";
    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one operation per cycle and queues its expected outputs
    task automatic step(input bit v, input int code, input int ptr, input int sel,
                        input string tag);
        exp_t e;
        bit isld;
        int mode, rn;
        logic [15:0] a, ix, nv, val;
        @(negedge clk);
        op_valid = v; op_code = code[3:0]; ptr_sel = ptr[1:0]; reg_sel = sel[4:0];
        e.re = 0; e.we = 0; e.pc = 0; e.addr = '0; e.wdata = '0; e.tag = tag;
        e.rfwe = p_ld; e.rfa = p_a; e.rfd = p_d; e.wtag = p_tag;
        p_ld = 0;
        if (v && code < 12) begin
            isld = (code < 4) || code == 8 || code == 9;
            mode = (code < 8) ? code % 4 : ((code % 2 == 0) ? 2 : 3);
            rn   = (code < 8) ? sel : ((code < 10) ? 24 + sel % 4 : 28 + sel % 4);
            a  = m_reg[ptr];
            ix = m_reg[ptr + 4];
            e.addr = a;
            e.pc   = (code < 8);
            val    = '0;
            if (isld) begin
                e.re = 1; val = m_mem[a[7:0]];
            end else begin
                e.we = 1; e.wdata = m_reg[rn]; m_mem[a[7:0]] = e.wdata;
            end
            case (mode)
                1: nv = a - 16'd1;
                2: nv = a + 16'd1;
                3: nv = a + ix;
                default: nv = a;
            endcase
            m_reg[ptr] = nv;
            if (isld) begin
                m_reg[rn] = val;
                p_ld = 1; p_a = rn[4:0]; p_d = val; p_tag = tag;
            end
        end
        q.push_back(e);
    endtask

    // Monitor: samples shortly before the rising edge and compares
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(mem_re == e.re, e.tag, "mem_re", 16'(mem_re), 16'(e.re));
                chk(mem_we == e.we, e.tag, "mem_we", 16'(mem_we), 16'(e.we));
                chk(pc_step == e.pc, "R8", "pc_step", 16'(pc_step), 16'(e.pc));
                if (e.re || e.we)
                    chk(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
                if (e.we)
                    chk(mem_wdata == e.wdata, e.tag, "mem_wdata", mem_wdata, e.wdata);
                chk(rf_we == e.rfwe, "R5", "rf_we", 16'(rf_we), 16'(e.rfwe));
                if (e.rfwe) begin
                    chk(rf_waddr == e.rfa, e.wtag, "rf_waddr", 16'(rf_waddr), 16'(e.rfa));
                    chk(rf_wdata == e.rfd, e.wtag, "rf_wdata", rf_wdata, e.rfd);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #(PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog run did not finish actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]   = 16'(i * 16'h9E37) ^ 16'h5A5A;
            m_mem[i] = ram[i];
        end
        for (int i = 0; i < 32; i++) begin
            ext_rf[i] = (i < 8) ? 16'h0 : 16'(i * 16'h1111 + 16'h0321);
            m_reg[i]  = ext_rf[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset, all pointers read zero
        repeat (3) step(0, 0, 0, 0, "R1");
        for (int p = 0; p < 4; p++) step(1, 0, p, 16, "R1");

        // R2: load index r4, use it at once through pointer 0 (also R10)
        step(1, 0, 0, 4, "R2");
        step(1, 3, 0, 8, "R2");
        step(1, 4, 1, 4, "R2");
        step(1, 4, 1, 0, "R2");

        // R12: wrap below zero and above 0xFFFF on pointer 1
        step(1, 1, 1, 9, "R12");
        step(1, 2, 1, 9, "R12");
        step(1, 0, 1, 9, "R12");

        // R9: load into own pointer with post-increment
        step(1, 2, 2, 2, "R9");
        step(1, 0, 2, 9, "R9");
        step(0, 0, 0, 0, "R9");
        step(1, 0, 2, 9, "R9");

        // R6 and R7: extended forms
        step(1, 8, 3, 1, "R6");
        step(1, 9, 3, 2, "R6");
        step(1, 10, 0, 3, "R7");
        step(1, 11, 0, 0, "R7");

        // R10: store source forwarded from the previous load
        step(1, 0, 1, 20, "R10");
        step(1, 4, 1, 20, "R10");
        step(1, 0, 3, 3, "R10");
        step(1, 7, 3, 3, "R10");

        // R11: undefined and idle codes leave state unchanged
        step(1, 12, 0, 0, "R11");
        step(1, 15, 1, 5, "R11");
        step(0, 2, 2, 1, "R11");
        step(1, 4, 0, 0, "R11");

        // R4: all store variants
        for (int c = 4; c < 8; c++) step(1, c, c % 4, c + 3, "R4");

        // R3 and mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int c, s;
            string t;
            c = $urandom % 14;
            s = ($urandom % 3 == 0) ? ($urandom % 8) : ($urandom % 32);
            if (c < 4)       t = "R3";
            else if (c < 8)  t = "R4";
            else if (c < 10) t = "R6";
            else if (c < 12) t = "R7";
            else             t = "R11";
            step(($urandom % 8) != 0, c, $urandom % 4, s, t);
        end

        repeat (3) step(0, 0, 0, 0, "R11");
        @(negedge clk);
        #5;
        summary();
        $finish;
    end

endmodule